// File: doc/BRIEF.md
# Fully Parallel Symmetric Distributed-Arithmetic FIR Filter

This block is a linear-phase FIR filter that takes one signed sample per clock and delivers one filtered result per clock. It uses no multipliers. The impulse response is mirror-symmetric, so each pair of samples that share a coefficient is added first. This halves the number of distinct products. The folded sums are split into groups of five taps. For every bit position of the folded words, each group has its own partial-sum unit. That unit turns five address bits into the sum of the selected coefficients. It uses a small computed table for four of the taps and a select-and-add for the fifth.

The per-bit partial sums are weighted by powers of two and summed, with the sign bit's term subtracted. The group results are then added. Registers split the path into five stages, so a full result emerges every cycle at a fixed latency. An input valid strobe marks the cycles that carry a real sample. A cycle without it leaves the sample history untouched. The output valid strobe is that input strobe delayed by the pipeline depth.

Top module: `dafir_top`

## Requirements
- R1: While reset is asserted and right after it is released, `outValid` is 0 and `outData` is 0; the sample history starts as all zeros.
- R2: For each accepted sample, `outData` equals the sum over k = 0..NUM_TAPS-1 of h(k)·x(n-k). Here x(n-k) is the k-th most recent accepted sample, with zero before the first. h(k) = h(NUM_TAPS-1-k) = c(min(k, NUM_TAPS-1-k)), and c(j) = 301·(j+1) − 1100.
- R3: A sample captured at rising edge E gives its result, with `outValid` high, right after edge E+4. Back-to-back samples give back-to-back results.
- R4: A cycle with `inValid` low does not shift the history, so gaps between samples leave every result unchanged.
- R5: While `outValid` is low, `outData` holds the last result delivered.
- R6: Input samples are 13-bit two's complement. A run of the most negative value (−4096) and a run of the most positive value (+4095) both give exact results. This requires the pre-added sign bit to carry negative weight.
- R7: A single sample of 1 followed by zeros yields the impulse response h(0), h(1), …, h(NUM_TAPS-1) on successive results.
- R8: A full-scale history whose signs match each tap's coefficient sign gives the largest-magnitude result without wrap-around. No result ever exceeds sum|c|·2^DATA_W in magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks a cycle carrying a new sample |
| inSample | input | DATA_W (13) | Signed input sample |
| outValid | output | 1 | Marks a cycle carrying a new result |
| outData | output | OUT_W (30) | Signed filter result |

## Verification
A sample is captured at rising edge E. It then passes through the pre-add, partial-sum, group-sum and output registers, so its result appears after edge E+4. The bench records the cycle number of every driven sample in a queue along with its expected value. At each falling edge where `outValid` is high, it compares both the data and the elapsed cycle count, which must be exactly five. On falling edges where `outValid` is low, it confirms that `outData` still holds the previous result.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  localparam int PIPE_DEPTH = 5;

  typedef struct packed {
    logic loadHist;
    logic loadPre;
    logic loadPart;
    logic loadGroup;
    logic loadOut;
  } stageStrobes_t;

  // folded coefficient j (0 = outermost tap pair)
  function automatic int dafirCoef(input int idx);
    return (idx + 1) * 301 - 1100;
  endfunction

  function automatic longint dafirAbsSum(input int count);
    longint acc;
    int c;
    acc = 0;
    for (int i = 0; i < count; i++) begin
      c = dafirCoef(i);
      acc += (c < 0) ? longint'(-c) : longint'(c);
    end
    return acc;
  endfunction

endpackage

// File: rtl/dafir_bitslice.sv
module dafir_bitslice
  import dafir_pkg::*;
#(
  parameter int GROUP_SIZE = 5,
  parameter int BASE       = 0,
  parameter int NUM_HALF   = 10,
  parameter int PART_W     = 16
) (
  input  logic [GROUP_SIZE-1:0]     sliceAddr,
  output logic signed [PART_W-1:0]  partial
);
  localparam int LUT_BITS  = GROUP_SIZE - 1;
  localparam int LUT_WORDS = 1 << LUT_BITS;
  localparam int TOP_TAP   = BASE + LUT_BITS;

  function automatic int tableEntry(input int addr);
    int acc;
    acc = 0;
    for (int i = 0; i < LUT_BITS; i++)
      if (((addr >> i) & 1) == 1 && (BASE + i) < NUM_HALF)
        acc += dafirCoef(BASE + i);
    return acc;
  endfunction

  logic signed [PART_W-1:0] lowTable [LUT_WORDS];
  logic signed [PART_W-1:0] topTerm;

  for (genvar a = 0; a < LUT_WORDS; a++) begin : g_lut
    assign lowTable[a] = PART_W'(tableEntry(a));
  end

  if (TOP_TAP < NUM_HALF) begin : g_top
    assign topTerm = sliceAddr[LUT_BITS] ? PART_W'(dafirCoef(TOP_TAP)) : '0;
  end else begin : g_notop
    logic unusedTop;
    assign unusedTop = sliceAddr[LUT_BITS];
    assign topTerm   = '0;
  end

  assign partial = lowTable[sliceAddr[LUT_BITS-1:0]] + topTerm;

endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic [PIPE_DEPTH-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
  end

  always_comb begin
    strobes.loadHist  = inValid;
    strobes.loadPre   = validPipe[0];
    strobes.loadPart  = validPipe[1];
    strobes.loadGroup = validPipe[2];
    strobes.loadOut   = validPipe[3];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];

endmodule

// File: rtl/dafir_datapath.sv
module dafir_datapath
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS   = 20,
  parameter int DATA_W     = 13,
  parameter int COEF_W     = 12,
  parameter int GROUP_SIZE = 5,
  parameter int OUT_W      = 30
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  stageStrobes_t             strobes,
  input  logic signed [DATA_W-1:0]  inSample,
  output logic signed [OUT_W-1:0]   outData
);
  localparam int NUM_HALF   = NUM_TAPS / 2;
  localparam int PRE_W      = DATA_W + 1;
  localparam int NUM_GROUPS = (NUM_HALF + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int PAD_TAPS   = NUM_GROUPS * GROUP_SIZE;
  localparam int PART_W     = COEF_W + $clog2(GROUP_SIZE) + 1;
  localparam int GROUP_W    = PART_W + PRE_W;

  // stage 1: sample history
  logic signed [DATA_W-1:0] history [NUM_TAPS];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TAPS; i++) history[i] <= '0;
    end else if (strobes.loadHist) begin
      history[0] <= inSample;
      for (int i = 1; i < NUM_TAPS; i++) history[i] <= history[i-1];
    end
  end

  // stage 2: fold mirrored pairs
  logic signed [PRE_W-1:0] preSum [NUM_HALF];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < NUM_HALF; j++) preSum[j] <= '0;
    end else if (strobes.loadPre) begin
      for (int j = 0; j < NUM_HALF; j++)
        preSum[j] <= PRE_W'(history[j]) + PRE_W'(history[NUM_TAPS-1-j]);
    end
  end

  logic signed [PRE_W-1:0] preSumPad [PAD_TAPS];
  for (genvar j = 0; j < PAD_TAPS; j++) begin : g_pad
    if (j < NUM_HALF) begin : g_real
      assign preSumPad[j] = preSum[j];
    end else begin : g_zero
      assign preSumPad[j] = '0;
    end
  end

  // stage 3: one partial-sum unit per group and bit position
  logic signed [PART_W-1:0] partNext [NUM_GROUPS][PRE_W];
  logic signed [PART_W-1:0] partReg  [NUM_GROUPS][PRE_W];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    for (genvar b = 0; b < PRE_W; b++) begin : g_bit
      logic [GROUP_SIZE-1:0] sliceAddr;
      for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_addr
        assign sliceAddr[i] = preSumPad[g*GROUP_SIZE+i][b];
      end
      dafir_bitslice #(
        .GROUP_SIZE (GROUP_SIZE),
        .BASE       (g*GROUP_SIZE),
        .NUM_HALF   (NUM_HALF),
        .PART_W     (PART_W)
      ) u_slice (
        .sliceAddr (sliceAddr),
        .partial   (partNext[g][b])
      );
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int b = 0; b < PRE_W; b++) partReg[g][b] <= '0;
    end else if (strobes.loadPart) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        for (int b = 0; b < PRE_W; b++) partReg[g][b] <= partNext[g][b];
    end
  end

  // stage 4: shift-weighted sum per group, sign bit subtracted
  logic signed [GROUP_W-1:0] groupNext [NUM_GROUPS];
  logic signed [GROUP_W-1:0] groupReg  [NUM_GROUPS];

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      groupNext[g] = '0;
      for (int b = 0; b < PRE_W; b++) begin
        if (b == PRE_W - 1)
          groupNext[g] = groupNext[g] - (GROUP_W'(partReg[g][b]) <<< b);
        else
          groupNext[g] = groupNext[g] + (GROUP_W'(partReg[g][b]) <<< b);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NUM_GROUPS; g++) groupReg[g] <= '0;
    end else if (strobes.loadGroup) begin
      for (int g = 0; g < NUM_GROUPS; g++) groupReg[g] <= groupNext[g];
    end
  end

  // stage 5: sum of groups
  logic signed [OUT_W-1:0] totalNext;
  always_comb begin
    totalNext = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      totalNext = totalNext + OUT_W'(groupReg[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                outData <= '0;
    else if (strobes.loadOut) outData <= totalNext;
  end

endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS   = 20,
  parameter int DATA_W     = 13,
  parameter int COEF_W     = 12,
  parameter int GROUP_SIZE = 5,
  localparam int OUT_W     = COEF_W + DATA_W + 1 + $clog2(NUM_TAPS / 2)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic signed [DATA_W-1:0]  inSample,
  output logic                      outValid,
  output logic signed [OUT_W-1:0]   outData
);
  stageStrobes_t strobes;

  dafir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  dafir_datapath #(
    .NUM_TAPS   (NUM_TAPS),
    .DATA_W     (DATA_W),
    .COEF_W     (COEF_W),
    .GROUP_SIZE (GROUP_SIZE),
    .OUT_W      (OUT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inSample (inSample),
    .outData  (outData)
  );

endmodule

// File: rtl/dafir_chk.sv
module dafir_chk
  import dafir_pkg::*;
#(
  parameter int NUM_TAPS = 20,
  parameter int DATA_W   = 13,
  parameter int OUT_W    = 30
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     outValid,
  input logic signed [OUT_W-1:0]  outData
);
  localparam longint LIMIT = dafirAbsSum(NUM_TAPS / 2) * (longint'(1) << DATA_W);

  logic [PIPE_DEPTH-1:0] shadowValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowValid <= '0;
    else       shadowValid <= {shadowValid[PIPE_DEPTH-2:0], inValid};
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> (!outValid && outData == '0));

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == shadowValid[PIPE_DEPTH-1]);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (longint'(outData) <= LIMIT && longint'(outData) >= -LIMIT));

endmodule

bind dafir_top dafir_chk #(
  .NUM_TAPS (NUM_TAPS),
  .DATA_W   (DATA_W),
  .OUT_W    (OUT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/test_dafir_top.sv
module test_dafir_top;
  localparam int NUM_TAPS = 20;
  localparam int DATA_W   = 13;
  localparam int OUT_W    = 12 + DATA_W + 1 + $clog2(NUM_TAPS / 2);
  localparam int QDEPTH   = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] inSample = '0;
  logic outValid;
  logic signed [OUT_W-1:0] outData;

  dafir_top #(.NUM_TAPS(NUM_TAPS)) i_dafir_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit done = 0;
  bit seenOut = 0;
  longint lastOut = 0;

  longint expQ [QDEPTH];
  int     cycQ [QDEPTH];
  string  tagQ [QDEPTH];
  int wrPtr = 0;
  int rdPtr = 0;
  longint modelHist [NUM_TAPS];

  always @(posedge clk) cycle <= cycle + 1;

  function automatic longint benchCoef(input int j);
    return longint'((j + 1) * 301 - 1100);
  endfunction

  function automatic longint benchTap(input int k);
    return benchCoef((k < NUM_TAPS / 2) ? k : NUM_TAPS - 1 - k);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic drive(input bit valid, input int value, input string tag);
    longint acc;
    @(negedge clk);
    inValid  = valid;
    inSample = DATA_W'(value);
    if (valid) begin
      for (int k = NUM_TAPS - 1; k > 0; k--) modelHist[k] = modelHist[k-1];
      modelHist[0] = longint'(value);
      acc = 0;
      for (int k = 0; k < NUM_TAPS; k++) acc += benchTap(k) * modelHist[k];
      expQ[wrPtr % QDEPTH] = acc;
      cycQ[wrPtr % QDEPTH] = cycle;
      tagQ[wrPtr % QDEPTH] = tag;
      wrPtr++;
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (rdPtr == wrPtr) begin
          check(0, "R4", 1, 0, "outValid with no pending sample");
        end else begin
          check(longint'(outData) == expQ[rdPtr % QDEPTH], tagQ[rdPtr % QDEPTH],
                longint'(outData), expQ[rdPtr % QDEPTH], "result value");
          check(cycle == cycQ[rdPtr % QDEPTH] + 5, "R3",
                longint'(cycle - cycQ[rdPtr % QDEPTH]), 5, "latency in cycles");
          rdPtr++;
        end
        lastOut = longint'(outData);
        seenOut = 1;
      end else if (seenOut) begin
        check(longint'(outData) == lastOut, "R5", longint'(outData), lastOut, "hold while idle");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 200000);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    for (int k = 0; k < NUM_TAPS; k++) modelHist[k] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", longint'(outValid), 0, "outValid in reset");
    check(outData == '0, "R1", longint'(outData), 0, "outData in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", longint'(outValid), 0, "outValid after release");
    check(outData == '0, "R1", longint'(outData), 0, "outData after release");

    // R7: impulse response
    drive(1, 1, "R7");
    for (int i = 0; i < NUM_TAPS + 2; i++) drive(1, 0, "R7");
    drive(0, 0, "R5");
    repeat (8) drive(0, 0, "R5");

    // R2/R3: back-to-back random
    for (int i = 0; i < 300; i++) drive(1, int'($urandom_range(0, 8191)) - 4096, "R2");

    // R4: random gaps
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = 1'($urandom_range(0, 1));
      drive(v, int'($urandom_range(0, 8191)) - 4096, "R4");
    end

    // R6: full-scale runs
    for (int i = 0; i < NUM_TAPS + 2; i++) drive(1, -4096, "R6");
    for (int i = 0; i < NUM_TAPS + 2; i++) drive(1, 4095, "R6");
    for (int i = 0; i < NUM_TAPS + 2; i++) drive(1, (i % 2 == 0) ? -4096 : 4095, "R6");

    // R8: sign-matched extremes, both polarities
    for (int k = NUM_TAPS - 1; k >= 0; k--) drive(1, (benchTap(k) < 0) ? -4096 : 4095, "R8");
    for (int k = NUM_TAPS - 1; k >= 0; k--) drive(1, (benchTap(k) < 0) ? 4095 : -4096, "R8");

    repeat (12) drive(0, 0, "R5");
    check(rdPtr == wrPtr, "R3", longint'(rdPtr), longint'(wrPtr), "all results delivered");

    done = 1;
    summary();
    $finish;
  end

endmodule